// File: doc/BRIEF.md
# Prioritized Pending Interrupt Controller

This block keeps one pending flag for each of fourteen interrupt sources of a processor core and, whenever no request is outstanding, picks the single highest-priority flag that its enable conditions allow. The chosen source is registered and presented as a one-hot exception request. The request stays stable until the core acknowledges it. On acknowledge, the flag of an edge-type source is cleared. The two external inputs are level-type: their flags simply follow the input pins, so taking them clears nothing.

Edge-type flags are set by one-cycle pulses from the timer and event logic. Doorbell messages also reach the block. A message carries a type, a target tag and a broadcast flag, and it either sends (sets) or withdraws (clears) the normal or the critical doorbell flag of this core. The core identifies itself through an ID input, which the send path compares with the message tag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until a source becomes eligible, `req_valid_o` is 0 and `req_src_o` is all zeros. All edge-type flags reset to 0.
- R2: Source bit positions give the priority, with bit 0 the highest: 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable timer, 9 decrementer, 10 external, 11 doorbell, 12 performance monitor, 13 thermal. When idle, the lowest-numbered eligible source is latched. It appears on the outputs one clock after it becomes eligible.
- R3: While `req_valid_o` is 1, `req_src_o` is one-hot, and it stays unchanged until a cycle with `ack_i` high. The cycle after an acknowledge has no request. Arbitration resumes the cycle after that.
- R4: An acknowledged edge-type source has its flag cleared. A set pulse for the same source in the acknowledge cycle wins, so the flag remains pending.
- R5: The external (bit 10) and critical external (bit 4) flags equal `ext_lvl_i` and `cext_lvl_i`. They are never cleared by being taken, and they are requested again after an acknowledge while their input stays high.
- R6: The hypervisor decrementer is eligible only when `hdec_en_i` is 1 and at least one of the following holds: `ee_i` is 1, `hv_i` is 0, or `pr_i` is 1.
- R7: With `ee_i` at 0, these sources are not eligible: watchdog, fixed-interval, programmable timer, decrementer, external, doorbell, performance monitor and thermal. Reset, machine check, debug, critical external and critical doorbell ignore `ee_i`.
- R8: Doorbell type 0 addresses the normal doorbell (bit 11) and type 1 the critical doorbell (bit 6). Any other type value, including the guest types 2 to 4, changes no flag.
- R9: A send message (`db_clear_i` 0) sets its flag only when `db_bcast_i` is 1 or `db_tag_i` equals `my_id_i`.
- R10: A clear message (`db_clear_i` 1) of type 0 or 1 clears the matching local flag whatever its tag and broadcast bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set_i | input | 14 | One-cycle set pulses per source (bits 4 and 10 unused) |
| ext_lvl_i | input | 1 | External interrupt level |
| cext_lvl_i | input | 1 | Critical external interrupt level |
| ee_i | input | 1 | External-enable state bit |
| hv_i | input | 1 | Hypervisor mode state bit |
| pr_i | input | 1 | Problem (user) state bit |
| hdec_en_i | input | 1 | Hypervisor decrementer enable control bit |
| my_id_i | input | TAG_W | This core's processor ID |
| db_valid_i | input | 1 | Doorbell message strobe |
| db_clear_i | input | 1 | 1 = clear message, 0 = send message |
| db_type_i | input | TYPE_W | Doorbell message type |
| db_bcast_i | input | 1 | Broadcast flag of the message |
| db_tag_i | input | TAG_W | Target processor tag of the message |
| ack_i | input | 1 | Acknowledge of the presented request |
| req_valid_o | output | 1 | Exception request present |
| req_src_o | output | 14 | One-hot code of the requested source |

## Verification
The hardest state to reach is a collision of events on one flag in one cycle, such as an acknowledge that lands in the same cycle as a fresh set pulse for the same source. The bench drives the ack and the pulse together and checks that the source is presented again. Level inputs changing while a lower-priority level request is being held form a second hard case. The stimulus raises the critical external level under a held external request, then drops it after repeated re-requests. Doorbell tag matching is exercised under four different processor IDs, with matching, non-matching and broadcast tags, and with clear messages that carry a foreign tag while the flag is masked and still pending.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC = 14;

  // bit position = priority rank, 0 highest
  localparam int S_RESET  = 0;
  localparam int S_MCHK   = 1;
  localparam int S_DEBUG  = 2;
  localparam int S_HDEC   = 3;
  localparam int S_CEXT   = 4;
  localparam int S_WDOG   = 5;
  localparam int S_CDB    = 6;
  localparam int S_FIXT   = 7;
  localparam int S_PROGT  = 8;
  localparam int S_DEC    = 9;
  localparam int S_EXT    = 10;
  localparam int S_DB     = 11;
  localparam int S_PERF   = 12;
  localparam int S_THERM  = 13;

  localparam logic [NSRC-1:0] LEVEL_MASK =
    NSRC'((1 << S_EXT) | (1 << S_CEXT));

  localparam logic [NSRC-1:0] EE_MASK =
    NSRC'((1 << S_WDOG) | (1 << S_FIXT) | (1 << S_PROGT) | (1 << S_DEC) |
          (1 << S_EXT) | (1 << S_DB) | (1 << S_PERF) | (1 << S_THERM));

  // doorbell message type codes
  localparam int DBT_NORMAL = 0;
  localparam int DBT_CRIT   = 1;
endpackage

// File: rtl/pic_db_decode.sv
module pic_db_decode
  import pic_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_valid_i,
  input  logic              db_clear_i,
  input  logic [TYPE_W-1:0] db_type_i,
  input  logic              db_bcast_i,
  input  logic [TAG_W-1:0]  db_tag_i,
  input  logic [TAG_W-1:0]  my_id_i,
  output logic [NSRC-1:0]   db_set_o,
  output logic [NSRC-1:0]   db_clr_o
);
  logic [NSRC-1:0] sel;
  logic            tgt_hit;

  always_comb begin
    sel = '0;
    if (int'(db_type_i) == DBT_NORMAL) sel[S_DB]  = 1'b1;
    if (int'(db_type_i) == DBT_CRIT)   sel[S_CDB] = 1'b1;
    tgt_hit  = db_bcast_i || (db_tag_i == my_id_i);
    db_set_o = (db_valid_i && !db_clear_i && tgt_hit) ? sel : '0;
    db_clr_o = (db_valid_i && db_clear_i) ? sel : '0;
  end

  // R9: a set only leaves for a send message aimed at this core
  p_send_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (db_set_o != '0) |-> (db_valid_i && !db_clear_i &&
                          (db_bcast_i || db_tag_i == my_id_i)));
  // R8: only the two doorbell flags are ever touched
  p_only_db_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((db_set_o | db_clr_o) & ~NSRC'((1 << S_DB) | (1 << S_CDB))) == '0);
endmodule

// File: rtl/pic_pending.sv
module pic_pending
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] take_clr_i,
  input  logic [NSRC-1:0] db_set_i,
  input  logic [NSRC-1:0] db_clr_i,
  input  logic            ext_lvl_i,
  input  logic            cext_lvl_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] set_all;
  logic [NSRC-1:0] clr_all;
  logic            unused_level_bits;

  assign set_all = set_i | db_set_i;
  assign clr_all = take_clr_i | db_clr_i;
  assign unused_level_bits = ^(set_all & LEVEL_MASK) ^ ^(clr_all & LEVEL_MASK);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (i == S_EXT) begin : g_ext
      assign pend_o[i] = ext_lvl_i;
    end else if (i == S_CEXT) begin : g_cext
      assign pend_o[i] = cext_lvl_i;
    end else begin : g_edge
      logic flag_q, flag_d, flag_en;
      always_comb begin
        flag_en = set_all[i] | clr_all[i];
        flag_d  = set_all[i];  // a new set wins over any clear
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (flag_en) flag_q <= flag_d;
      end
      assign pend_o[i] = flag_q;

      // R4: a clear with no competing set leaves the flag low
      p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all[i] && !set_all[i]) |=> !pend_o[i]);
      // R4: a set always lands
      p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_all[i] |=> pend_o[i]);
    end
  end
endmodule

// File: rtl/pic_pick.sv
module pic_pick #(
  parameter int N = 14
) (
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic [N-1:0] above;  // some higher-priority bit is eligible

  for (genvar i = 0; i < N; i++) begin : g_chain
    if (i == 0) begin : g_top
      assign above[i] = 1'b0;
    end else begin : g_rest
      assign above[i] = above[i-1] | elig_i[i-1];
    end
    assign grant_o[i] = elig_i[i] & ~above[i];
  end

  assign any_o = |elig_i;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import pic_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_set_i,
  input  logic              ext_lvl_i,
  input  logic              cext_lvl_i,
  input  logic              ee_i,
  input  logic              hv_i,
  input  logic              pr_i,
  input  logic              hdec_en_i,
  input  logic [TAG_W-1:0]  my_id_i,
  input  logic              db_valid_i,
  input  logic              db_clear_i,
  input  logic [TYPE_W-1:0] db_type_i,
  input  logic              db_bcast_i,
  input  logic [TAG_W-1:0]  db_tag_i,
  input  logic              ack_i,
  output logic              req_valid_o,
  output logic [NSRC-1:0]   req_src_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NSRC-1:0] db_set, db_clr, pend, gate, elig, grant, take_clr;
  logic            any_elig, hdec_ok;
  logic            rv_q, rv_d, rv_en;
  logic [NSRC-1:0] rs_q, rs_d;

  pic_db_decode #(.TAG_W(TAG_W), .TYPE_W(TYPE_W)) u_db (
    .clk(clk), .rst_n(rst_sync_q),
    .db_valid_i(db_valid_i), .db_clear_i(db_clear_i), .db_type_i(db_type_i),
    .db_bcast_i(db_bcast_i), .db_tag_i(db_tag_i), .my_id_i(my_id_i),
    .db_set_o(db_set), .db_clr_o(db_clr)
  );

  pic_pending u_pend (
    .clk(clk), .rst_n(rst_sync_q),
    .set_i(src_set_i), .take_clr_i(take_clr),
    .db_set_i(db_set), .db_clr_i(db_clr),
    .ext_lvl_i(ext_lvl_i), .cext_lvl_i(cext_lvl_i),
    .pend_o(pend)
  );

  always_comb begin
    hdec_ok = hdec_en_i && (ee_i || !hv_i || pr_i);
    gate    = ee_i ? '1 : ~EE_MASK;
    gate[S_HDEC] = hdec_ok;
    elig    = pend & gate;
  end

  pic_pick #(.N(NSRC)) u_pick (
    .elig_i(elig), .grant_o(grant), .any_o(any_elig)
  );

  // request register: next state
  always_comb begin
    rv_d     = rv_q;
    rs_d     = rs_q;
    rv_en    = 1'b0;
    take_clr = '0;
    if (rv_q) begin
      if (ack_i) begin
        rv_en    = 1'b1;
        rv_d     = 1'b0;
        rs_d     = '0;
        take_clr = rs_q & ~LEVEL_MASK;
      end
    end else if (any_elig) begin
      rv_en = 1'b1;
      rv_d  = 1'b1;
      rs_d  = grant;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rv_q <= 1'b0;
      rs_q <= '0;
    end else if (rv_en) begin
      rv_q <= rv_d;
      rs_q <= rs_d;
    end
  end

  assign req_valid_o = rv_q;
  assign req_src_o   = rs_q;

  // R3: code is one-hot with a request, empty without
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    req_valid_o ? $onehot(req_src_o) : (req_src_o == '0));
  // R3: held stable until acknowledged
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_valid_o && !ack_i) |=> (req_valid_o && $stable(req_src_o)));
  // R3: an acknowledge always leaves one empty cycle
  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_valid_o && ack_i) |=> !req_valid_o);
  // R6: hypervisor decrementer never latched while gated off
  p_hdec_gate_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!req_valid_o && !(hdec_en_i && (ee_i || !hv_i || pr_i)))
      |=> !req_src_o[S_HDEC]);
  // R7: maskable sources never latched while external-enable is 0
  p_ee_mask_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!req_valid_o && !ee_i) |=> ((req_src_o & EE_MASK) == '0));
  // R5: a held level input is requested right after the idle cycle
  p_level_again_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!req_valid_o && ext_lvl_i && ee_i) |=> req_valid_o);
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  localparam int N = 14;
  localparam int TAG_W = 8;
  localparam int TYPE_W = 3;
  localparam int I_EXT = 10, I_CEXT = 4, I_HDEC = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic              rst_n;
  logic [N-1:0]      src_set;
  logic              ext_lvl, cext_lvl, ee, hv, pr, hdec_en;
  logic [TAG_W-1:0]  my_id;
  logic              db_valid, db_clear, db_bcast;
  logic [TYPE_W-1:0] db_type;
  logic [TAG_W-1:0]  db_tag;
  logic              ack;
  logic              req_valid;
  logic [N-1:0]      req_src;

  irq_prio_ctrl #(.TAG_W(TAG_W), .TYPE_W(TYPE_W)) uut (
    .clk(clk), .rst_n(rst_n), .src_set_i(src_set),
    .ext_lvl_i(ext_lvl), .cext_lvl_i(cext_lvl), .ee_i(ee), .hv_i(hv),
    .pr_i(pr), .hdec_en_i(hdec_en), .my_id_i(my_id),
    .db_valid_i(db_valid), .db_clear_i(db_clear), .db_type_i(db_type),
    .db_bcast_i(db_bcast), .db_tag_i(db_tag), .ack_i(ack),
    .req_valid_o(req_valid), .req_src_o(req_src)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // behavioural reference state
  bit m_pend [N];
  bit m_rv;
  int m_src;

  function automatic bit maskable(int i);
    return (i == 5 || i == 7 || i == 8 || i == 9 || i == 10 ||
            i == 11 || i == 12 || i == 13);
  endfunction

  function automatic bit allowed(int i);
    if (i == I_HDEC) return hdec_en && (ee || !hv || pr);
    if (maskable(i)) return ee;
    return 1'b1;
  endfunction

  function automatic int db_index(int t);
    if (t == 0) return 11;
    if (t == 1) return 6;
    return -1;
  endfunction

  task automatic tick();
    bit np [N];
    bit cur [N];
    bit nrv;
    int nsrc;
    int di;
    for (int i = 0; i < N; i++) begin
      np[i] = m_pend[i];
      cur[i] = m_pend[i];
    end
    cur[I_EXT] = ext_lvl;
    cur[I_CEXT] = cext_lvl;
    nrv = m_rv;
    nsrc = m_src;
    if (m_rv) begin
      if (ack) begin
        nrv = 1'b0;
        if (m_src != I_EXT && m_src != I_CEXT) np[m_src] = 1'b0;
      end
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (cur[i] && allowed(i)) begin
          nrv = 1'b1;
          nsrc = i;
        end
    end
    di = db_index(int'(db_type));
    if (db_valid && db_clear && di >= 0) np[di] = 1'b0;
    for (int i = 0; i < N; i++)
      if (src_set[i] && i != I_EXT && i != I_CEXT) np[i] = 1'b1;
    if (db_valid && !db_clear && di >= 0 && (db_bcast || db_tag == my_id))
      np[di] = 1'b1;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_pend[i] = 1'b0;
      m_rv = 1'b0;
      m_src = 0;
    end else begin
      for (int i = 0; i < N; i++) m_pend[i] = np[i];
      m_rv = nrv;
      m_src = nsrc;
    end
    vectors++;
    if (req_valid !== m_rv || req_src !== (m_rv ? N'(1) << m_src : N'(0))) begin
      miscompares++;
      $display("FAIL R2/R3 model compare: got valid=%0b src=%h, expected valid=%0b src=%h",
               req_valid, req_src, m_rv, m_rv ? N'(1) << m_src : N'(0));
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic expect_req(string rq, bit v, int idx);
    logic [N-1:0] es;
    es = v ? N'(1) << idx : N'(0);
    vectors++;
    if (req_valid !== v || req_src !== es) begin
      miscompares++;
      $display("FAIL %s: got valid=%0b src=%h, expected valid=%0b src=%h",
               rq, req_valid, req_src, v, es);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic pulse_src(logic [N-1:0] bits);
    src_set = bits;
    tick();
    src_set = '0;
  endtask

  task automatic send_db(bit clr, int t, bit bc, int tag);
    db_valid = 1'b1;
    db_clear = clr;
    db_type = TYPE_W'(t);
    db_bcast = bc;
    db_tag = TAG_W'(tag);
    tick();
    db_valid = 1'b0;
    db_clear = 1'b0;
    db_bcast = 1'b0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    miscompares++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_set = '0; ext_lvl = 0; cext_lvl = 0;
    ee = 1; hv = 0; pr = 0; hdec_en = 0; my_id = '0;
    db_valid = 0; db_clear = 0; db_type = '0; db_bcast = 0; db_tag = '0;
    ack = 0;
    m_rv = 0; m_src = 0;
    for (int i = 0; i < N; i++) m_pend[i] = 0;

    ticks(3);
    expect_req("R1 in reset", 0, 0);
    rst_n = 1'b1;
    ticks(4);
    expect_req("R1 after reset", 0, 0);

    // R2/R3/R4: three edge sources at once
    pulse_src(N'((1 << 7) | (1 << 9) | (1 << 13)));
    tick();
    expect_req("R2 fixed-interval first", 1, 7);
    ticks(3);
    expect_req("R3 held without ack", 1, 7);
    do_ack();
    expect_req("R3 gap after ack", 0, 0);
    tick();
    expect_req("R2 decrementer next", 1, 9);
    do_ack(); tick();
    expect_req("R2 thermal last", 1, 13);
    do_ack(); ticks(2);
    expect_req("R4 all taken flags cleared", 0, 0);

    // R2: every edge source pending together
    hdec_en = 1;
    pulse_src('1);
    for (int i = 0; i < N; i++) begin
      if (i == I_EXT || i == I_CEXT) continue;
      tick();
      expect_req("R2 full order", 1, i);
      do_ack();
    end
    tick();
    expect_req("R2 drained", 0, 0);
    hdec_en = 0;

    // R5: level inputs
    ext_lvl = 1;
    tick();
    expect_req("R5 external", 1, I_EXT);
    do_ack();
    expect_req("R5 gap", 0, 0);
    tick();
    expect_req("R5 external again", 1, I_EXT);
    cext_lvl = 1;
    tick();
    expect_req("R3 held under new level", 1, I_EXT);
    do_ack(); tick();
    expect_req("R5 critical external", 1, I_CEXT);
    do_ack(); tick();
    expect_req("R5 critical external again", 1, I_CEXT);
    cext_lvl = 0;
    do_ack(); tick();
    expect_req("R5 external after critical drop", 1, I_EXT);
    ext_lvl = 0;
    do_ack(); ticks(2);
    expect_req("R5 levels gone", 0, 0);

    // R6: hypervisor decrementer gating
    pulse_src(N'(1 << I_HDEC));
    ticks(3);
    expect_req("R6 enable bit clear", 0, 0);
    hdec_en = 1; hv = 1; ee = 0; pr = 0;
    ticks(2);
    expect_req("R6 hv=1 ee=0 pr=0", 0, 0);
    pr = 1;
    tick();
    expect_req("R6 problem state opens", 1, I_HDEC);
    do_ack();
    pr = 0; hv = 0; ee = 1; hdec_en = 0;
    tick();
    expect_req("R6 cleared", 0, 0);

    // R7: external-enable masking
    ee = 0;
    pulse_src(N'((1 << 9) | (1 << 12) | (1 << 5)));
    ticks(3);
    expect_req("R7 maskable held off", 0, 0);
    pulse_src(N'(1 << 1));
    tick();
    expect_req("R7 machine check ignores ee", 1, 1);
    do_ack();
    ee = 1;
    tick();
    expect_req("R7 watchdog after unmask", 1, 5);
    do_ack(); tick();
    expect_req("R7 decrementer after unmask", 1, 9);
    do_ack(); tick();
    expect_req("R7 perf monitor after unmask", 1, 12);
    do_ack(); tick();

    // R9: doorbell targeting across four IDs
    for (int id = 0; id < 4; id++) begin
      my_id = TAG_W'(id);
      send_db(0, 0, 0, id);
      tick();
      expect_req("R9 matching tag", 1, 11);
      do_ack();
      send_db(0, 0, 0, (id + 1) % 4);
      ticks(2);
      expect_req("R9 foreign tag ignored", 0, 0);
      send_db(0, 1, 1, (id + 2) % 4);
      tick();
      expect_req("R9 broadcast critical", 1, 6);
      do_ack();
      tick();
    end

    // R8: other types ignored
    my_id = '0;
    for (int t = 2; t < 8; t++) begin
      send_db(0, t, 1, 0);
      ticks(2);
      expect_req("R8 other type ignored", 0, 0);
    end

    // R10: clear message with foreign tag
    ee = 0;
    send_db(0, 0, 0, 0);
    send_db(1, 0, 0, 9);
    ee = 1;
    ticks(2);
    expect_req("R10 clear withdrew doorbell", 0, 0);

    // R4: set in the acknowledge cycle wins
    pulse_src(N'(1 << 7));
    tick();
    expect_req("R4 setup", 1, 7);
    ack = 1; src_set = N'(1 << 7);
    tick();
    ack = 0; src_set = '0;
    tick();
    expect_req("R4 set beats take-clear", 1, 7);
    do_ack(); ticks(2);
    expect_req("R4 finally clear", 0, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule